// File: doc/BRIEF.md
# Lookahead Incrementer

This block adds a one-bit carry-in to an operand of parameter width and returns the sum and a carry-out. It has no clock and no state. Both outputs change in the same cycle as the inputs. It is a carry-lookahead adder whose second operand is fixed at zero, so the lookahead logic has been reduced to match. No bit ever generates a carry, so a carry reaches a bit position only when the carry-in is high and every lower operand bit is one. Each sum bit is then the operand bit XORed with the carry that arrives at it.

The operand is split into 4-bit groups. Each group has a small lookahead unit. The unit builds its three internal carries from flat AND terms over its inputs and reports a group propagate, which is the AND of its four inputs. The group propagates feed further lookahead units one level up, in a tree. The carry-in enters at the root. The carries come back down the tree to the bit cells. The carry-in is a live input, so the same block either increments or passes the operand through.

Top module: `lookahead_incrementer`

## Requirements
- R1: When `carry_in` is 0, `sum` equals `op_a` and `carry_out` is 0.
- R2: When `carry_in` is 1, `{carry_out, sum}` equals `op_a + 1`, computed at WIDTH+1 bits.
- R3: `carry_out` is 1 exactly when `carry_in` is 1 and every bit of `op_a` is 1. In that case `sum` is all zeros.
- R4: When `carry_in` is 1 and bit k is the lowest 0 bit of `op_a`, bits 0 to k of `sum` are the inverse of the matching bits of `op_a`. All bits above k equal `op_a`. This holds when k lies in any 4-bit group, including a group other than the one holding bit 0.
- R5: The block is purely combinational. After an input change, the outputs settle without any clock edge.
- R6: WIDTH is a parameter and must be a multiple of 4. Widths whose group count is not a power of four, such as 24, behave as R1 to R4 state. The unused inputs of the lookahead tree are padded with propagate = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand to be incremented |
| carry_in | input | 1 | Value added to the operand (0 or 1) |
| sum | output | WIDTH | Low WIDTH bits of op_a + carry_in |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case to reach is a carry that must travel through the second lookahead level. That happens when the lowest zero bit of the operand sits in a high group, which needs every lower group to be exactly all ones. Random operands almost never produce this, because the chance falls by a factor of two for each extra bit of ones. The stimulus therefore builds operands on purpose. For each bit position k, the bits below k are set to ones, bit k is cleared, and the bits above k are random. Every group boundary and every lookahead level is crossed this way. A second instance at width 24 sends the same patterns through a tree with padded inputs.

// File: rtl/inc_pkg.sv
// Package: inc_pkg
// Purpose : constant functions that size the lookahead tree of the
//           incrementer from its operand width.
// Assumes : widths are positive; callers pass multiples of 4.
package inc_pkg;

    localparam int RADIX = 4;

    // Number of nodes at tree level k: ceil(n / 4^k).
    function automatic int node_count(input int n, input int k);
        int v;
        v = n;
        for (int i = 0; i < k; i++) begin
            v = (v + RADIX - 1) / RADIX;
        end
        return v;
    endfunction

    // Number of lookahead levels needed to reduce n bits to one node.
    function automatic int level_count(input int n);
        int l;
        l = 1;
        while (node_count(n, l) > 1) begin
            l++;
        end
        return l;
    endfunction

    // Bit offset of level k inside the flattened per-level vectors
    // (each level occupies 4 * units-at-that-level bits).
    function automatic int lane_offset(input int n, input int k);
        int s;
        s = 0;
        for (int m = 0; m < k; m++) begin
            s += RADIX * node_count(n, m + 1);
        end
        return s;
    endfunction

    // Offset of level k inside the flattened group-propagate vector.
    function automatic int group_offset(input int n, input int k);
        int s;
        s = 0;
        for (int m = 0; m < k; m++) begin
            s += node_count(n, m + 1);
        end
        return s;
    endfunction

endpackage

// File: rtl/inc_bit_cell.sv
// Module : inc_bit_cell
// Purpose: one sum bit of the incrementer. The second operand bit is 0,
//          so the sum is the operand bit XOR the incoming carry.
// Assumes: the carry comes from the lookahead tree, not a ripple chain.
module inc_bit_cell (
    input  logic a_bit,
    input  logic c_bit,
    output logic s_bit
);

    // Sum bit: operand XOR carry.
    always_comb begin
        s_bit = a_bit ^ c_bit;
    end

endmodule

// File: rtl/inc_la4.sv
// Module : inc_la4
// Purpose: 4-input lookahead unit specialised for generate = 0.
//          Carries are flat AND terms of the carry-in and the lower
//          propagates; the group propagate is the AND of all four.
// Assumes: no input ever generates a carry by itself.
module inc_la4 (
    input  logic [3:0] p_in,
    input  logic       c_in,
    output logic [3:0] c_vec,
    output logic       grp_p
);

    // Carry into each of the four positions, two-level AND form.
    always_comb begin
        c_vec[0] = c_in;
        c_vec[1] = c_in & p_in[0];
        c_vec[2] = c_in & p_in[0] & p_in[1];
        c_vec[3] = c_in & p_in[0] & p_in[1] & p_in[2];
    end

    // Group propagate handed to the next level up.
    always_comb begin
        grp_p = p_in[0] & p_in[1] & p_in[2] & p_in[3];
    end

endmodule

// File: rtl/inc_la_level.sv
// Module : inc_la_level
// Purpose: one level of the lookahead tree, a row of UNITS inc_la4
//          units side by side.
// Assumes: inputs beyond the real node count are already padded to 1
//          by the caller.
module inc_la_level #(
    parameter int UNITS = 1,
    localparam int LANES = 4 * UNITS
) (
    input  logic [LANES-1:0] p_lanes,
    input  logic [UNITS-1:0] c_units,
    output logic [LANES-1:0] c_lanes,
    output logic [UNITS-1:0] p_units
);

    // One lookahead unit per group of four lanes.
    for (genvar j = 0; j < UNITS; j++) begin : g_unit
        inc_la4 u_la4 (
            .p_in  (p_lanes[4*j +: 4]),
            .c_in  (c_units[j]),
            .c_vec (c_lanes[4*j +: 4]),
            .grp_p (p_units[j])
        );
    end

endmodule

// File: rtl/lookahead_incrementer.sv
// Module : lookahead_incrementer
// Purpose: adds carry_in to op_a with a multi-level carry-lookahead
//          tree built from generate-free lookahead units.
// Assumes: WIDTH is a multiple of 4. There is no clock or state, so no
//          reset is needed.
module lookahead_incrementer #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    import inc_pkg::*;

    localparam int LEVELS    = level_count(WIDTH);
    localparam int LANE_TOT  = lane_offset(WIDTH, LEVELS);
    localparam int GROUP_TOT = group_offset(WIDTH, LEVELS);

    // Flattened per-level propagate inputs, carries and group propagates.
    logic [LANE_TOT-1:0]  prop_all;
    logic [LANE_TOT-1:0]  carry_all;
    logic [GROUP_TOT-1:0] grp_all;
    logic                 root_prop;

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int UNITS  = node_count(WIDTH, k + 1);
        localparam int NODES  = node_count(WIDTH, k);
        localparam int LOFF   = lane_offset(WIDTH, k);
        localparam int GOFF   = group_offset(WIDTH, k);
        logic [UNITS-1:0] c_units;

        // Propagate inputs of this level: operand bits or lower groups.
        if (k == 0) begin : g_leaf
            assign prop_all[LOFF +: WIDTH] = op_a;
        end else begin : g_inner
            localparam int PGOFF = group_offset(WIDTH, k - 1);
            for (genvar i = 0; i < 4 * UNITS; i++) begin : g_lane
                if (i < NODES) begin : g_real
                    assign prop_all[LOFF + i] = grp_all[PGOFF + i];
                end else begin : g_pad
                    assign prop_all[LOFF + i] = 1'b1;
                end
            end
        end

        // Carries into this level's units: from the level above, or carry_in at the root.
        if (k == LEVELS - 1) begin : g_root
            assign c_units = carry_in;
        end else begin : g_from_up
            assign c_units = carry_all[lane_offset(WIDTH, k + 1) +: UNITS];
        end

        inc_la_level #(
            .UNITS (UNITS)
        ) u_level (
            .p_lanes (prop_all[LOFF +: 4 * UNITS]),
            .c_units (c_units),
            .c_lanes (carry_all[LOFF +: 4 * UNITS]),
            .p_units (grp_all[GOFF +: UNITS])
        );
    end

    // Propagate of the whole operand, taken from the root unit.
    assign root_prop = grp_all[GROUP_TOT - 1];

    // Sum bits from operand and the leaf-level carries.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        inc_bit_cell u_cell (
            .a_bit (op_a[b]),
            .c_bit (carry_all[b]),
            .s_bit (sum[b])
        );
    end

    // Carry-out: carry_in propagated through every operand bit.
    always_comb begin
        carry_out = carry_in & root_prop;
    end

endmodule

// File: rtl/inc_checker.sv
// Module : inc_checker
// Purpose: port-level immediate assertions for lookahead_incrementer.
// Assumes: purely combinational DUT, so checks run on settled values.
module inc_checker #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);

    // Evaluate every rule whenever a port changes.
    always_comb begin
        AST_PASS_THROUGH: assert (carry_in || (sum == op_a && !carry_out)) else $error("pass-through broken"); // R1
        AST_SUM_VALUE: assert ({carry_out, sum} == ({1'b0, op_a} + {{WIDTH{1'b0}}, carry_in})) else $error("sum mismatch"); // R2
        AST_CARRY_OUT: assert (carry_out == (carry_in && (op_a == {WIDTH{1'b1}}))) else $error("carry-out mismatch"); // R3
        AST_WRAP_ZERO: assert (!carry_out || sum == '0) else $error("wrap not zero"); // R3
        AST_LOW_FLIP: assert (!carry_in || sum[0] != op_a[0]) else $error("lsb did not flip"); // R4
    end

endmodule

bind lookahead_incrementer inc_checker #(
    .WIDTH (WIDTH)
) u_chk (
    .op_a      (op_a),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/lookahead_incrementer_tb.sv
`timescale 1ns/1ps
module lookahead_incrementer_tb;

    localparam int W  = 16;
    localparam int WB = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic          carry_in = 1'b0;
    logic [W-1:0]  sum;
    logic          carry_out;
    logic [WB-1:0] op_b = '0;
    logic          cin_b = 1'b0;
    logic [WB-1:0] sum_b;
    logic          cout_b;
    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lookahead_incrementer #(.WIDTH(W)) u_dut (
        .op_a(op_a), .carry_in(carry_in), .sum(sum), .carry_out(carry_out));

    lookahead_incrementer #(.WIDTH(WB)) u_dut_w24 (
        .op_a(op_b), .carry_in(cin_b), .sum(sum_b), .carry_out(cout_b));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge and sample 1 ns later.
    task automatic apply(input logic [W-1:0] a, input logic c);
        @(negedge clk);
        op_a = a;
        carry_in = c;
        #1;
    endtask

    function automatic logic [63:0] ref16(input logic [W-1:0] a, input logic c);
        return 64'(a) + 64'(c);
    endfunction

    task automatic t_reset_state();
        rst_n = 1'b0;
        apply('0, 1'b0);
        check("R1 reset sum", 64'(sum), 64'h0);
        check("R1 reset cout", 64'(carry_out), 64'h0);
        @(posedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_pass_through();
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] a;
            a = W'($urandom);
            if (i == 0) a = '1;
            apply(a, 1'b0);
            check("R1 pass", {47'b0, carry_out, sum}, 64'(a));
        end
    endtask

    task automatic t_increment();
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a;
            a = W'($urandom);
            apply(a, 1'b1);
            check("R2 inc", {47'b0, carry_out, sum}, ref16(a, 1'b1));
        end
        apply('0, 1'b1);
        check("R2 zero+1", {47'b0, carry_out, sum}, 64'h1);
    endtask

    task automatic t_carry_out();
        apply('1, 1'b1);
        check("R3 cout all ones", 64'(carry_out), 64'h1);
        check("R3 sum wraps", 64'(sum), 64'h0);
        apply('1, 1'b0);
        check("R3 no cin", {47'b0, carry_out, sum}, 64'hFFFF);
        apply(16'hFFFE, 1'b1);
        check("R3 one zero bit", {47'b0, carry_out, sum}, 64'hFFFF);
    endtask

    task automatic t_trailing_ones();
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] low_mask;
            logic [W-1:0] a;
            low_mask = W'((64'h1 << (k + 1)) - 1);
            a = (W'($urandom) & ~low_mask) | (low_mask >> 1);
            apply(a, 1'b1);
            check($sformatf("R4 lowest zero at %0d", k), 64'(sum), 64'(a ^ low_mask));
            check("R4 no cout", 64'(carry_out), 64'h0);
        end
    endtask

    task automatic t_no_clock();
        @(posedge clk);
        #0.5;
        op_a = 16'h0FFF;
        carry_in = 1'b1;
        #1;
        check("R5 settles before edge", {47'b0, carry_out, sum}, 64'h1000);
        carry_in = 1'b0;
        #0.5;
        check("R5 follows cin", {47'b0, carry_out, sum}, 64'h0FFF);
    endtask

    task automatic t_wide();
        for (int k = 0; k < WB; k++) begin
            logic [WB-1:0] low_mask;
            logic [WB-1:0] b;
            low_mask = WB'((64'h1 << (k + 1)) - 1);
            b = (WB'($urandom) & ~low_mask) | (low_mask >> 1);
            @(negedge clk);
            op_b = b;
            cin_b = 1'b1;
            #1;
            check("R6 w24 inc", {39'b0, cout_b, sum_b}, 64'(b) + 64'h1);
        end
        @(negedge clk);
        op_b = '1;
        cin_b = 1'b1;
        #1;
        check("R6 w24 wrap", {39'b0, cout_b, sum_b}, 64'h1000000);
        @(negedge clk);
        op_b = 24'hA5A5A5;
        cin_b = 1'b0;
        #1;
        check("R6 w24 pass", {39'b0, cout_b, sum_b}, 64'hA5A5A5);
    endtask

    initial begin
        t_reset_state();
        t_pass_through();
        t_increment();
        t_carry_out();
        t_trailing_ones();
        t_no_clock();
        t_wide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule